// File: doc/BRIEF.md
# Addressed Multi-Byte Serial Register Port

This block is the slave end of a three-wire serial control bus: a serial clock, a data line that turns around for reads, and an optional active-low select. It holds a small register bank: a 16-bit data word, a 16-bit command word, a 24-bit offset-calibration word and a 24-bit gain-calibration word. All four are presented as plain outputs to the converter logic next to it.

Every transfer opens with an instruction byte. This byte picks read or write, a length of one to three bytes and a start address. The data bytes follow. After each byte the address steps up, or steps down when the command word says so. The bit order inside a data byte can also be reversed by the command word.

Written bytes collect in a shadow copy. They reach the outputs together on the falling clock edge of the final bit. The serial clock, data and select are brought into the system clock through two-flop synchronizers, so the serial clock must run at no more than one tenth of the system clock. The data line is split into `sdio_in`, `sdio_out` and `sdio_oe` for a pad cell to combine.

Top module: `srp_port`

## Requirements
- R1: After reset: data word 0x0000, command word 0x1900, both calibration words 0x000000, and `sdio_oe` low.
- R2: The instruction byte is always received MSB first. Its fields are:
  - bit 7: 0 = write, 1 = read.
  - bits 6:5: byte count, where 00 = 1 byte, 01 = 2 bytes, 10 = 3 bytes, and 11 is also taken as 3 bytes.
  - bit 4: ignored.
  - bits 3:0: start address.
- R3: The address map is:
  - 0: data word high byte; 1: data word low byte.
  - 4: command word high byte; 5: command word low byte.
  - 8, 9, A: offset word bits 23:16, 15:8, 7:0.
  - C, D, E: gain word bits 23:16, 15:8, 7:0.
  - Every other address is reserved: a read of it returns 0x00 and a write to it is dropped.
- R4: After each data byte the address steps by +1 when command bit 2 is 0 and by -1 when command bit 2 is 1. The address is 4 bits wide and wraps modulo 16.
- R5: Data bytes move MSB first when command bit 1 is 0 and LSB first when command bit 1 is 1, for both reads and writes.
- R6: `sdio_in` is sampled on the falling serial-clock edge. Read bits are driven after the rising edge. `sdio_oe` is high only from the first rising edge after a read instruction until the falling edge of the read's last bit.
- R7: Written bytes change no output until the falling edge of the transfer's last bit. They then all appear at once. Reads return committed values.
- R8: Command bits 15, 12, 11 and 10 always read 0, 1, 1 and 0 whatever is written.
- R9: A high select during an instruction or a write clears the bit and byte counters, and the partial transfer is dropped. A high select during the data phase of a read does not stop the read or release `sdio_oe`.
- R10: With the select held low, the bit after a transfer's last byte starts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low select, may be tied low |
| sdio_in | input | 1 | Serial data from the bus master |
| sdio_out | output | 1 | Serial read data |
| sdio_oe | output | 1 | Drive enable for the data pad |
| data_word | output | 16 | Committed data word |
| cmd_word | output | 16 | Committed command word |
| offset_cal | output | 24 | Committed offset-calibration word |
| gain_cal | output | 24 | Committed gain-calibration word |

## Verification
The hardest case to reach is a transfer that changes its own framing. A multi-byte write to the command word flips the step direction or the bit order. That change must not take effect until the transfer ends.

The bench first writes the command word with one ordering. It then runs walking reads and writes in the other orderings, computing every byte's address and bit position from its own model. The select is also dropped in the middle of an instruction, in the middle of a write byte, and during a read, to show that only the read survives.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W   = 4;
  localparam int BYTE_W   = 8;
  localparam int DAT_W    = 16;
  localparam int CMD_W    = 16;
  localparam int CAL_W    = 24;
  localparam int BITCNT_W = $clog2(BYTE_W);

  localparam logic [CMD_W-1:0] CMD_RESET = 16'h1900;
  localparam logic [CMD_W-1:0] CMD_KEEP  = 16'h63FF;
  localparam logic [CMD_W-1:0] CMD_SET   = 16'h1800;
  localparam int CMD_DIR_BIT = 2;
  localparam int CMD_LSB_BIT = 1;

  typedef struct packed {
    logic [DAT_W-1:0] dat;
    logic [CMD_W-1:0] cmd;
    logic [CAL_W-1:0] ofs;
    logic [CAL_W-1:0] gain;
  } bank_t;

  localparam bank_t BANK_RESET = '{dat: '0, cmd: CMD_RESET, ofs: '0, gain: '0};

  function automatic logic [BYTE_W-1:0] bank_rd(input bank_t b, input logic [ADDR_W-1:0] a);
    logic [BYTE_W-1:0] r;
    case (a)
      4'h0:    r = b.dat[15:8];
      4'h1:    r = b.dat[7:0];
      4'h4:    r = b.cmd[15:8];
      4'h5:    r = b.cmd[7:0];
      4'h8:    r = b.ofs[23:16];
      4'h9:    r = b.ofs[15:8];
      4'hA:    r = b.ofs[7:0];
      4'hC:    r = b.gain[23:16];
      4'hD:    r = b.gain[15:8];
      4'hE:    r = b.gain[7:0];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic bank_t bank_wr(input bank_t b, input logic [ADDR_W-1:0] a,
                                    input logic [BYTE_W-1:0] v);
    bank_t n;
    n = b;
    case (a)
      4'h0:    n.dat[15:8]   = v;
      4'h1:    n.dat[7:0]    = v;
      4'h4:    n.cmd[15:8]   = v;
      4'h5:    n.cmd[7:0]    = v;
      4'h8:    n.ofs[23:16]  = v;
      4'h9:    n.ofs[15:8]   = v;
      4'hA:    n.ofs[7:0]    = v;
      4'hC:    n.gain[23:16] = v;
      4'hD:    n.gain[15:8]  = v;
      4'hE:    n.gain[7:0]   = v;
      default: n = b;
    endcase
    n.cmd = (n.cmd & CMD_KEEP) | CMD_SET;
    return n;
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/srp_seq.sv
module srp_seq
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              sdio_s,
  input  logic              dir_down,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              load_shadow,
  output logic              wr_en,
  output logic              wr_last,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sclk_rise,
  output logic              sclk_fall
);
  logic                sclk_d;
  logic                phase_data;
  logic                rw_q;
  logic [BITCNT_W-1:0] bit_cnt;
  logic [1:0]          left;
  logic [BYTE_W-1:0]   shreg;
  logic                abort;
  logic                byte_done;
  logic [BYTE_W-1:0]   data_byte;
  logic [BYTE_W-1:0]   ins_byte;
  logic [BITCNT_W-1:0] bit_sel;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  // a read in its data phase keeps going when select is raised
  assign abort     = cs_s & ~(phase_data & rw_q);
  assign byte_done = sclk_fall & (bit_cnt == BITCNT_W'(BYTE_W - 1));
  assign data_byte = lsb_first ? {sdio_s, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], sdio_s};
  assign ins_byte  = {shreg[BYTE_W-2:0], sdio_s};
  assign bit_sel   = lsb_first ? bit_cnt : ~bit_cnt;

  assign load_shadow = ~abort & byte_done & ~phase_data;
  assign wr_en       = ~abort & byte_done & phase_data & ~rw_q;
  assign wr_last     = wr_en & (left == 2'd0);
  assign wr_byte     = data_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      phase_data <= 1'b0;
      rw_q       <= 1'b0;
      bit_cnt    <= '0;
      left       <= '0;
      shreg      <= '0;
      cur_addr   <= '0;
      sdio_out   <= 1'b0;
      sdio_oe    <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (abort) begin
        phase_data <= 1'b0;
        bit_cnt    <= '0;
        shreg      <= '0;
      end else begin
        if (sclk_fall) begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= phase_data ? data_byte : ins_byte;
          if (byte_done) begin
            if (!phase_data) begin
              phase_data <= 1'b1;
              rw_q       <= shreg[6];
              left       <= (shreg[5:4] == 2'b11) ? 2'd2 : shreg[5:4];
              cur_addr   <= {shreg[2:0], sdio_s};
            end else begin
              cur_addr <= dir_down ? cur_addr - 1'b1 : cur_addr + 1'b1;
              left     <= left - 1'b1;
              if (left == 2'd0) begin
                phase_data <= 1'b0;
                sdio_oe    <= 1'b0;
              end
            end
          end
        end
        if (sclk_rise && phase_data && rw_q) begin
          sdio_oe  <= 1'b1;
          sdio_out <= rd_byte[bit_sel];
        end
      end
    end
  end
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_shadow,
  input  logic              wr_en,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output bank_t             live
);
  bank_t shadow;
  bank_t shadow_nxt;

  assign shadow_nxt = bank_wr(shadow, addr, wr_byte);
  assign rd_byte    = bank_rd(live, addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= BANK_RESET;
      shadow <= BANK_RESET;
    end else begin
      if (load_shadow) shadow <= live;
      if (wr_en) begin
        shadow <= shadow_nxt;
        if (wr_last) live <= shadow_nxt;
      end
    end
  end
endmodule

// File: rtl/srp_port.sv
module srp_port
  import srp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdio_in,
  output logic             sdio_out,
  output logic             sdio_oe,
  output logic [DAT_W-1:0] data_word,
  output logic [CMD_W-1:0] cmd_word,
  output logic [CAL_W-1:0] offset_cal,
  output logic [CAL_W-1:0] gain_cal
);
  localparam int SYNC_STAGES = 2;

  logic [2:0]        sync_q;
  logic              sclk_s, cs_s, sdio_s;
  logic [ADDR_W-1:0] cur_addr;
  logic              load_shadow, wr_en, wr_last;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic              sclk_rise, sclk_fall;
  bank_t             live;

  srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, sdio_in}), .q(sync_q)
  );
  assign {sclk_s, cs_s, sdio_s} = sync_q;

  srp_seq seq_i (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .sdio_s(sdio_s),
    .dir_down(live.cmd[CMD_DIR_BIT]), .lsb_first(live.cmd[CMD_LSB_BIT]),
    .rd_byte(rd_byte), .cur_addr(cur_addr), .load_shadow(load_shadow),
    .wr_en(wr_en), .wr_last(wr_last), .wr_byte(wr_byte),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  srp_bank bank_i (
    .clk(clk), .rst_n(rst_n), .load_shadow(load_shadow), .wr_en(wr_en),
    .wr_last(wr_last), .addr(cur_addr), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .live(live)
  );

  assign data_word  = live.dat;
  assign cmd_word   = live.cmd;
  assign offset_cal = live.ofs;
  assign gain_cal   = live.gain;
endmodule

// File: rtl/srp_port_chk.sv
module srp_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_rise,
  input logic        sclk_fall,
  input logic        load_shadow,
  input logic        wr_en,
  input logic        sdio_out,
  input logic        sdio_oe,
  input logic [15:0] data_word,
  input logic [15:0] cmd_word,
  input logic [23:0] offset_cal
);
  assert_cmd_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[15:10] & 6'b100111) == 6'b000110);

  assert_commit_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_word) || !$stable(offset_cal)) |-> $past(sclk_fall));

  assert_oe_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_rise));

  assert_out_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && !$past(sclk_rise)) |-> $stable(sdio_out));

  assert_no_load_and_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_shadow && wr_en));
endmodule

bind srp_port srp_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .load_shadow(load_shadow), .wr_en(wr_en), .sdio_out(sdio_out),
  .sdio_oe(sdio_oe), .data_word(data_word), .cmd_word(cmd_word),
  .offset_cal(offset_cal)
);

// File: tb/srp_port_tb_top.sv
module srp_port_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b0;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  logic [15:0] data_word, cmd_word;
  logic [23:0] offset_cal, gain_cal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_dat, m_cmd;
  logic [23:0] m_ofs, m_gain;

  always #2 clk = ~clk;

  srp_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .data_word(data_word),
    .cmd_word(cmd_word), .offset_cal(offset_cal), .gain_cal(gain_cal)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [3:0] a);
    case (a)
      4'h0: return m_dat[15:8];
      4'h1: return m_dat[7:0];
      4'h4: return m_cmd[15:8];
      4'h5: return m_cmd[7:0];
      4'h8: return m_ofs[23:16];
      4'h9: return m_ofs[15:8];
      4'hA: return m_ofs[7:0];
      4'hC: return m_gain[23:16];
      4'hD: return m_gain[15:8];
      4'hE: return m_gain[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_wr(input logic [3:0] a, input logic [7:0] v);
    case (a)
      4'h0: m_dat[15:8] = v;
      4'h1: m_dat[7:0] = v;
      4'h4: m_cmd[15:8] = v;
      4'h5: m_cmd[7:0] = v;
      4'h8: m_ofs[23:16] = v;
      4'h9: m_ofs[15:8] = v;
      4'hA: m_ofs[7:0] = v;
      4'hC: m_gain[23:16] = v;
      4'hD: m_gain[15:8] = v;
      4'hE: m_gain[7:0] = v;
      default: ;
    endcase
    m_cmd = (m_cmd & 16'h63FF) | 16'h1800;
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " data"}, {16'h0, data_word}, {16'h0, m_dat});
    chk({tag, " cmd"}, {16'h0, cmd_word}, {16'h0, m_cmd});
    chk({tag, " ofs"}, {8'h0, offset_cal}, {8'h0, m_ofs});
    chk({tag, " gain"}, {8'h0, gain_cal}, {8'h0, m_gain});
  endtask

  task automatic clk_bit(input logic b, output logic r, output logic oe);
    sdio_in = b;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    r = sdio_out;
    oe = sdio_oe;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_instr(input logic rw, input logic [1:0] nc, input logic [3:0] a);
    logic [7:0] ins;
    logic r, oe;
    ins = {rw, nc, 1'b0, a};
    for (int i = 7; i >= 0; i--) begin
      clk_bit(ins[i], r, oe);
      if (i == 0) chk("R6 oe low during instruction", {31'h0, oe}, 32'h0);
    end
  endtask

  // body of a transfer after the instruction; the model steps address and order
  task automatic xfer_body(input string tag, input logic rw, input logic [1:0] nc,
                           input logic [3:0] a, input logic [23:0] wb);
    int n;
    logic lsb, dn, r, oe;
    logic [3:0] addr;
    logic [3:0] pa [3];
    logic [7:0] pb [3];
    logic [7:0] b, got, exp;
    int idx;
    lsb = m_cmd[1];
    dn = m_cmd[2];
    n = (nc == 2'b11) ? 3 : int'(nc) + 1;
    addr = a;
    for (int bi = 0; bi < n; bi++) begin
      exp = m_rd(addr);
      b = wb[8*bi +: 8];
      got = 8'h00;
      for (int k = 0; k < 8; k++) begin
        idx = lsb ? k : 7 - k;
        clk_bit(b[idx], r, oe);
        got[idx] = r;
        if (rw && k == 0) chk({tag, " R6 oe high in read"}, {31'h0, oe}, 32'h1);
      end
      if (rw) chk({tag, " read byte"}, {24'h0, got}, {24'h0, exp});
      else begin
        pa[bi] = addr;
        pb[bi] = b;
        if (bi < n - 1) check_regs({tag, " R7 held before last byte"});
      end
      addr = dn ? addr - 4'd1 : addr + 4'd1;
    end
    if (!rw) begin
      for (int bi = 0; bi < n; bi++) m_wr(pa[bi], pb[bi]);
      check_regs({tag, " R7 commit"});
    end
    chk({tag, " R6 oe low after"}, {31'h0, sdio_oe}, 32'h0);
  endtask

  task automatic xfer(input string tag, input logic rw, input logic [1:0] nc,
                      input logic [3:0] a, input logic [23:0] wb);
    send_instr(rw, nc, a);
    xfer_body(tag, rw, nc, a, wb);
  endtask

  function automatic logic [7:0] sweep_val(input logic [3:0] a);
    logic [7:0] v;
    v = (8'(a) * 8'd37 + 8'd11) ^ 8'h5A;
    if (a == 4'h5) v = v & 8'hF9;
    return v;
  endfunction

  initial begin
    logic r, oe;
    m_dat = 16'h0000; m_cmd = 16'h1900; m_ofs = 24'h0; m_gain = 24'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_regs("R1 reset");
    chk("R1 oe at reset", {31'h0, sdio_oe}, 32'h0);

    // R3 sweep of every address, one byte each; back-to-back transfers (R10)
    for (int a = 0; a < 16; a++) xfer("R3 sweep write", 1'b0, 2'b00, 4'(a), {16'h0, sweep_val(4'(a))});
    for (int a = 0; a < 16; a++) xfer("R3 R10 sweep read", 1'b1, 2'b00, 4'(a), 24'h0);

    // R2 R4 multi-byte, upward
    xfer("R4 up write data", 1'b0, 2'b01, 4'h0, 24'h00_3C_C3);
    xfer("R4 up write ofs", 1'b0, 2'b10, 4'h8, 24'h96_5A_A5);
    xfer("R2 code11 write gain", 1'b0, 2'b11, 4'hC, 24'h0F_E1_7B);
    xfer("R4 up read data", 1'b1, 2'b01, 4'h0, 24'h0);
    xfer("R4 up read ofs", 1'b1, 2'b10, 4'h8, 24'h0);
    xfer("R2 code11 read gain", 1'b1, 2'b11, 4'hC, 24'h0);
    xfer("R3 read across reserved", 1'b1, 2'b10, 4'h1, 24'h0);

    // R8 fixed command bits
    xfer("R8 write cmd high", 1'b0, 2'b00, 4'h4, 24'h0000E6);
    chk("R8 cmd high byte", {24'h0, cmd_word[15:8]}, 32'h7A);

    // R4 downward: command low byte bit 2
    xfer("R4 set down", 1'b0, 2'b01, 4'h4, 24'h04_19);
    xfer("R4 down write data", 1'b0, 2'b01, 4'h1, 24'h81_42);
    xfer("R4 down read gain", 1'b1, 2'b10, 4'hE, 24'h0);
    xfer("R4 down wrap write", 1'b0, 2'b01, 4'h0, 24'h77_D2);
    xfer("R4 down wrap read", 1'b1, 2'b10, 4'h1, 24'h0);

    // R5 LSB-first: command low byte bit 1
    xfer("R5 set lsb", 1'b0, 2'b00, 4'h5, 24'h000002);
    xfer("R5 lsb write data", 1'b0, 2'b01, 4'h0, 24'h1E_B4);
    xfer("R5 lsb read data", 1'b1, 2'b01, 4'h0, 24'h0);
    xfer("R5 lsb read ofs", 1'b1, 2'b10, 4'h8, 24'h0);
    xfer("R5 lsb down", 1'b0, 2'b00, 4'h5, 24'h000006);
    xfer("R5 lsb down write ofs", 1'b0, 2'b10, 4'hA, 24'h3D_6E_C9);
    xfer("R5 lsb down read ofs", 1'b1, 2'b10, 4'hA, 24'h0);
    xfer("R5 back to msb", 1'b0, 2'b00, 4'h5, 24'h000000);
    xfer("R5 msb read data", 1'b1, 2'b01, 4'h0, 24'h0);

    // R9 select raised mid-instruction
    for (int i = 0; i < 4; i++) clk_bit(1'b0, r, oe);
    cs_n = 1'b1; repeat (HALF) @(negedge clk);
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
    xfer("R9 after instr abort", 1'b0, 2'b00, 4'h1, 24'h0000A5);

    // R9 select raised mid-write byte
    send_instr(1'b0, 2'b00, 4'h0);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, r, oe);
    cs_n = 1'b1; repeat (HALF) @(negedge clk);
    check_regs("R9 partial write dropped");
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
    xfer("R9 after write abort", 1'b0, 2'b00, 4'h9, 24'h00005C);

    // R9 select raised during read data phase
    send_instr(1'b1, 2'b10, 4'h8);
    cs_n = 1'b1;
    xfer_body("R9 read continues", 1'b1, 2'b10, 4'h8, 24'h0);
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
    xfer("R9 R10 after read", 1'b1, 2'b01, 4'h0, 24'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule